// File: doc/BRIEF.md
# I2C Identity Register Slave

This block is a serial-bus slave that answers at one fixed 7-bit address and exposes a nine-location byte space. Locations 0 through 7 hold a read-only 64-bit identity word built from a family code, a 48-bit serial number and a check byte. Location 8 holds a single writable mode bit. The clock and data lines are resynchronised and glitch-filtered into the system clock domain before any bus events are decoded. The slave only pulls SDA low or releases it, as an open-drain driver does.

A host that wants the identity sets the location pointer in a write access, then reads sequential bytes, usually after a repeated START. The pointer advances after every complete byte in either direction and wraps after location 8. Writes to the identity locations are refused with a NAK, but the pointer still advances. The mode bit drives the `mode_o` output.

The control state machine has these states. ST_IDLE waits for a START. ST_ADDR shifts in the address byte. ST_AACK drives the address ACK. ST_PTR shifts in the pointer byte. ST_PACK drives the pointer ACK. ST_WR shifts in a data byte. ST_WACK drives the data ACK. ST_RD shifts a byte out. ST_MACK samples the master's acknowledge. ST_IGNORE stays off the bus.

Transitions:
- A START from any state goes to ST_ADDR. A STOP from any state goes to ST_IDLE.
- After 8 bits, ST_ADDR goes to ST_AACK on an address match and to ST_IGNORE otherwise.
- ST_AACK goes to ST_RD for a read access and to ST_PTR for a write access.
- ST_PTR goes to ST_PACK if the value is 8 or less, and to ST_IGNORE otherwise.
- ST_PACK goes to ST_WR.
- ST_WR goes to ST_WACK when the pointer is 8, and to ST_IGNORE otherwise. ST_WACK goes back to ST_WR.
- ST_RD goes to ST_MACK.
- ST_MACK goes to ST_RD on a master ACK and to ST_IGNORE on a master NAK.

Top module: `i2c_id_slave`

## Requirements
- R1: The slave ACKs an address byte whose upper seven bits equal SLV_ADDR (default 7'b1010000). Bit 0 of that byte selects the direction: 0 for write, 1 for read. A byte carrying any other address is never ACKed and leaves the slave quiet until the next START or STOP.
- R2: In a write access, the byte after the address loads the pointer and is ACKed when its value is 00h to 08h. A value above 08h is NAKed and leaves the pointer unchanged.
- R3: A data byte written while the pointer is 00h to 07h is discarded and NAKed, and the pointer still advances by one.
- R4: The pointer resets to 00h. It advances after every complete data byte read or written, and it wraps from 08h to 00h.
- R5: Location 08h reads as seven zero bits above the mode bit in bit 0. The mode bit resets to 1. A write to 08h is ACKed and copies data bit 0 to the mode bit and to `mode_o`.
- R6: Reads return the following: location 00h gives FAMILY (default 70h), locations 01h to 06h give the SERIAL bytes with the least significant byte at 01h, and location 07h gives the check byte. The check byte is the CRC over polynomial x^8+x^5+x^4+1, taken with initial value 0 and shifted least significant bit first, over the family byte followed by the six serial bytes.
- R7: Bytes travel most significant bit first. The slave samples SDA on a rising SCL edge and changes its SDA pull only while SCL is low.
- R8: When the master NAKs a read byte, the slave releases SDA and drives nothing until the next START or STOP.
- R9: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A repeated START begins a new address phase and keeps the pointer.
- R10: After a NAKed pointer or data byte, the slave ACKs nothing until the next START or STOP.
- R11: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 enables the pad's low driver on SDA |
| mode_o | output | 1 | Current mode bit (location 08h bit 0) |

## Verification
The bench builds the slave with FILT_LEN set to 4. This makes a two-clock SCL pulse, inserted in the middle of a bit's low phase, short enough to be rejected. The bench also sets SERIAL to a pattern with six distinct bytes, so a swapped byte order or a misplaced check byte shows up as a wrong read value. The bench keeps the default address, so both a matching address and a near miss (1010001) can be driven on the same bus.

// File: rtl/id_slave_pkg.sv
package id_slave_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_PTR, ST_PACK,
        ST_WR, ST_WACK, ST_RD, ST_MACK, ST_IGNORE
    } slv_state_t;

    localparam int unsigned SPACE_LAST = 8;
    localparam int unsigned PTR_W      = $clog2(SPACE_LAST + 1);

    // Reflected CRC-8 (x^8+x^5+x^4+1), bit 0 of data shifted first.
    function automatic logic [7:0] id_crc8(input logic [55:0] data);
        logic [7:0] c;
        logic       fb;
        c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            fb = c[0] ^ data[i];
            c  = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int unsigned FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_f
);
    localparam int unsigned CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            run_q  <= '0;
            line_f <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] == line_f) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
                run_q  <= '0;
                line_f <= sync_q[1];
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign ev_start = scl_f & scl_q & sda_q & ~sda_f;
    assign ev_stop  = scl_f & scl_q & ~sda_q & sda_f;
    assign ev_rise  = scl_f & ~scl_q;
    assign ev_fall  = ~scl_f & scl_q;

    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_start, ev_stop, ev_rise, ev_fall})); // R9

endmodule

// File: rtl/id_byte_space.sv
module id_byte_space
    import id_slave_pkg::*;
#(
    parameter logic [7:0]  FAMILY = 8'h70,
    parameter logic [47:0] SERIAL = 48'h0000_0000_0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] ptr,
    input  logic             wr_en,
    input  logic             wr_bit,
    output logic [7:0]       rd_byte,
    output logic             mode
);
    localparam logic [7:0]  CHECK = id_crc8({SERIAL, FAMILY});
    localparam logic [63:0] IDENT = {CHECK, SERIAL, FAMILY};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     mode <= 1'b1;
        else if (wr_en) mode <= wr_bit;
    end

    always_comb begin
        if (ptr == PTR_W'(SPACE_LAST)) rd_byte = {7'b0, mode};
        else if (ptr < PTR_W'(SPACE_LAST)) rd_byte = IDENT[{ptr[2:0], 3'b000} +: 8];
        else rd_byte = 8'h00;
    end

endmodule

// File: rtl/i2c_id_slave.sv
module i2c_id_slave
    import id_slave_pkg::*;
#(
    parameter logic [6:0]  SLV_ADDR = 7'b1010000,
    parameter logic [7:0]  FAMILY   = 8'h70,
    parameter logic [47:0] SERIAL   = 48'h0000_0000_0001,
    parameter int unsigned FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull,
    output logic mode_o
);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(SPACE_LAST);

    logic [1:0] raw_lines, flt_lines;
    logic       ev_start, ev_stop, ev_rise, ev_fall;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .line_i(raw_lines[g]), .line_f(flt_lines[g]));
    end

    wire scl_f = flt_lines[1];
    wire sda_f = flt_lines[0];

    i2c_bus_events u_evt (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall));

    slv_state_t       st, nxt;
    logic [3:0]       bit_cnt;
    logic [7:0]       sh, tx;
    logic [PTR_W-1:0] ptr;
    logic             rw, mack;
    logic [7:0]       rd_byte;

    wire byte_done = (bit_cnt == 4'd8);
    wire addr_hit  = (sh[7:1] == SLV_ADDR);
    wire ptr_ok    = (sh <= 8'(SPACE_LAST));
    wire [PTR_W-1:0] ptr_inc = (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
    wire mode_wr   = ev_fall && (st == ST_WR) && byte_done && (ptr == PTR_LAST);

    id_byte_space #(.FAMILY(FAMILY), .SERIAL(SERIAL)) u_space (
        .clk(clk), .rst_n(rst_n), .ptr(ptr), .wr_en(mode_wr), .wr_bit(sh[0]),
        .rd_byte(rd_byte), .mode(mode_o));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Next state
    always_comb begin
        nxt = st;
        if (ev_start)     nxt = ST_ADDR;
        else if (ev_stop) nxt = ST_IDLE;
        else if (ev_fall) begin
            unique case (st)
                ST_ADDR:   if (byte_done) nxt = addr_hit ? ST_AACK : ST_IGNORE;
                ST_AACK:   nxt = rw ? ST_RD : ST_PTR;
                ST_PTR:    if (byte_done) nxt = ptr_ok ? ST_PACK : ST_IGNORE;
                ST_PACK:   nxt = ST_WR;
                ST_WR:     if (byte_done) nxt = (ptr == PTR_LAST) ? ST_WACK : ST_IGNORE;
                ST_WACK:   nxt = ST_WR;
                ST_RD:     if (byte_done) nxt = ST_MACK;
                ST_MACK:   nxt = mack ? ST_RD : ST_IGNORE;
                ST_IDLE, ST_IGNORE: nxt = st;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // Bit datapath and SDA pull
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            sh       <= '0;
            tx       <= '0;
            ptr      <= '0;
            rw       <= 1'b0;
            mack     <= 1'b0;
            sda_pull <= 1'b0;
        end else if (ev_start || ev_stop) begin
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
        end else begin
            if (ev_rise) begin
                if (st == ST_ADDR || st == ST_PTR || st == ST_WR) begin
                    sh      <= {sh[6:0], sda_f};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (st == ST_RD)   bit_cnt <= bit_cnt + 1'b1;
                if (st == ST_MACK) mack <= ~sda_f;
            end
            if (ev_fall) begin
                unique case (st)
                    ST_ADDR: if (byte_done) begin
                        rw <= sh[0]; sda_pull <= addr_hit; bit_cnt <= '0;
                    end
                    ST_AACK, ST_MACK: begin
                        bit_cnt <= '0;
                        if ((st == ST_AACK) ? rw : mack) begin
                            tx <= rd_byte; sda_pull <= ~rd_byte[7];
                        end else begin
                            sda_pull <= 1'b0;
                        end
                    end
                    ST_PTR: if (byte_done) begin
                        sda_pull <= ptr_ok; bit_cnt <= '0;
                        if (ptr_ok) ptr <= sh[PTR_W-1:0];
                    end
                    ST_PACK, ST_WACK: begin
                        sda_pull <= 1'b0; bit_cnt <= '0;
                    end
                    ST_WR: if (byte_done) begin
                        sda_pull <= (ptr == PTR_LAST); ptr <= ptr_inc; bit_cnt <= '0;
                    end
                    ST_RD: if (byte_done) begin
                        sda_pull <= 1'b0; ptr <= ptr_inc; bit_cnt <= '0;
                    end else begin
                        tx <= {tx[6:0], 1'b0}; sda_pull <= ~tx[6];
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PTR_LAST); // R4
    AST_MODE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> ptr == '0); // R5
    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_f); // R7
    AST_RX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR || st == ST_PTR || st == ST_WR) |-> !sda_pull); // R7
    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_IGNORE |-> !sda_pull); // R10

endmodule

// File: tb/sim_i2c_id_slave.sv
`timescale 1ns/1ps
module sim_i2c_id_slave;
    localparam logic [7:0]  FAM = 8'h70;
    localparam logic [47:0] SER = 48'hC3_5A_91_27_E4_0B;
    localparam int Q = 20;

    logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
    logic pull, mode;
    wire  sda_line = m_sda & ~pull;

    i2c_id_slave #(.FAMILY(FAM), .SERIAL(SER), .FILT_LEN(4)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_pull(pull), .mode_o(mode));

    always #2.5 clk = ~clk;

    int total = 0, bad = 0, r7_viol = 0;
    bit finished = 1'b0, pull_seen = 1'b0, scl_prev = 1'b1, pull_prev = 1'b0;

    always @(negedge clk) begin
        if (m_scl && scl_prev && pull != pull_prev) r7_viol++;
        if (pull) pull_seen = 1'b1;
        scl_prev  = m_scl;
        pull_prev = pull;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc();
        logic [7:0] c = 8'h00;
        logic [7:0] b;
        for (int k = 0; k < 7; k++) begin
            b = (k == 0) ? FAM : SER[(k-1)*8 +: 8];
            for (int j = 0; j < 8; j++) begin
                if (c[0] ^ b[j]) c = (c >> 1) ^ 8'h8C;
                else             c = c >> 1;
            end
        end
        return c;
    endfunction

    function automatic logic [7:0] exp_byte(input int a, input bit md);
        if (a == 0) return FAM;
        if (a <= 6) return SER[(a-1)*8 +: 8];
        if (a == 7) return ref_crc();
        return {7'b0, md};
    endfunction

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_scl = 1'b0; wclk(Q); m_sda = 1'b1; wclk(Q);
        m_scl = 1'b1; wclk(Q); m_sda = 1'b0; wclk(Q);
    endtask

    task automatic bus_stop();
        m_scl = 1'b0; wclk(Q); m_sda = 1'b0; wclk(Q);
        m_scl = 1'b1; wclk(Q); m_sda = 1'b1; wclk(Q);
    endtask

    task automatic bus_bit(input bit b, input bit glitch, output bit smp);
        m_scl = 1'b0; wclk(Q); m_sda = b; wclk(Q);
        if (glitch) begin m_scl = 1'b1; wclk(2); m_scl = 1'b0; wclk(Q); end
        m_scl = 1'b1; wclk(Q); smp = sda_line; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack, input int glitch_bit = -1);
        bit s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], i == glitch_bit, s);
        bus_bit(1'b1, 1'b0, s);
        ack = ~s;
    endtask

    task automatic read_byte(input bit m_ack, output logic [7:0] b);
        bit s;
        for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, 1'b0, s); b[i] = s; end
        bus_bit(~m_ack, 1'b0, s);
    endtask

    task automatic t_reset();
        check(pull == 1'b0, "R7 reset pull", pull, 0);
        check(mode == 1'b1, "R5 reset mode", mode, 1);
    endtask

    task automatic t_read_all();
        bit a; logic [7:0] b;
        bus_start(); send_byte(8'hA1, a);
        check(a, "R1 read address ack", a, 1);
        for (int i = 0; i < 10; i++) begin
            read_byte(i != 9, b);
            check(b == exp_byte(i % 9, 1'b1), "R6 R4 sequential read", b, exp_byte(i % 9, 1'b1));
        end
        bus_stop();
    endtask

    task automatic t_sr_read();
        bit a; logic [7:0] b;
        bus_start(); send_byte(8'hA0, a); send_byte(8'h05, a);
        check(a, "R2 pointer 05 ack", a, 1);
        bus_start(); send_byte(8'hA1, a); read_byte(1'b0, b);
        check(b == exp_byte(5, 1'b1), "R9 repeated start read", b, exp_byte(5, 1'b1));
        bus_stop();
    endtask

    task automatic t_bad_ptr();
        bit a; logic [7:0] b;
        bus_start(); send_byte(8'hA0, a); send_byte(8'h09, a);
        check(!a, "R2 pointer 09 nak", a, 0);
        send_byte(8'h00, a);
        check(!a, "R10 byte after nak", a, 0);
        bus_stop();
        bus_start(); send_byte(8'hA1, a); read_byte(1'b0, b);
        check(b == exp_byte(6, 1'b1), "R2 pointer kept", b, exp_byte(6, 1'b1));
        bus_stop();
    endtask

    task automatic t_rom_write();
        bit a; logic [7:0] b;
        bus_start(); send_byte(8'hA0, a); send_byte(8'h02, a); send_byte(8'hFF, a);
        check(!a, "R3 rom write nak", a, 0);
        bus_stop();
        bus_start(); send_byte(8'hA1, a); read_byte(1'b0, b);
        check(b == exp_byte(3, 1'b1), "R3 pointer advanced", b, exp_byte(3, 1'b1));
        bus_stop();
    endtask

    task automatic t_mode();
        bit a; logic [7:0] b;
        bus_start(); send_byte(8'hA0, a); send_byte(8'h08, a); send_byte(8'h00, a);
        check(a, "R5 mode write ack", a, 1);
        check(mode == 1'b0, "R5 mode cleared", mode, 0);
        send_byte(8'h55, a);
        check(!a, "R4 wrap to rom nak", a, 0);
        bus_stop();
        bus_start(); send_byte(8'hA0, a); send_byte(8'h08, a);
        bus_start(); send_byte(8'hA1, a); read_byte(1'b0, b);
        check(b == 8'h00, "R5 read mode 0", b, 0);
        bus_stop();
        bus_start(); send_byte(8'hA0, a); send_byte(8'h08, a); send_byte(8'hFF, a);
        bus_start(); send_byte(8'hA0, a); send_byte(8'h08, a);
        bus_start(); send_byte(8'hA1, a); read_byte(1'b0, b);
        check(b == 8'h01, "R5 upper bits zero", b, 1);
        check(mode == 1'b1, "R5 mode set", mode, 1);
        bus_stop();
    endtask

    task automatic t_wrong_addr();
        bit a;
        bus_start(); send_byte(8'hA2, a);
        check(!a, "R1 other address ignored", a, 0);
        send_byte(8'h08, a);
        check(!a, "R1 quiet after mismatch", a, 0);
        bus_stop();
    endtask

    task automatic t_master_nak();
        bit a; logic [7:0] b;
        bus_start(); send_byte(8'hA0, a); send_byte(8'h00, a);
        bus_start(); send_byte(8'hA1, a);
        read_byte(1'b1, b);
        check(b == exp_byte(0, 1'b1), "R7 msb first byte 0", b, exp_byte(0, 1'b1));
        read_byte(1'b0, b);
        check(b == exp_byte(1, 1'b1), "R7 msb first byte 1", b, exp_byte(1, 1'b1));
        wclk(Q);
        pull_seen = 1'b0;
        read_byte(1'b0, b);
        check(b == 8'hFF && !pull_seen, "R8 released after master nak", b, 8'hFF);
        bus_stop();
    endtask

    task automatic t_glitch();
        bit a; logic [7:0] b;
        bus_start(); send_byte(8'hA0, a); send_byte(8'h07, a, 3);
        check(a, "R11 pointer ack with glitch", a, 1);
        bus_start(); send_byte(8'hA1, a); read_byte(1'b0, b);
        check(b == exp_byte(7, 1'b1), "R11 glitch rejected", b, exp_byte(7, 1'b1));
        bus_stop();
    endtask

    initial begin
        wclk(5); rst_n = 1'b1; wclk(5);
        t_reset();
        t_read_all();
        t_sr_read();
        t_bad_ptr();
        t_rom_write();
        t_mode();
        t_wrong_addr();
        t_master_nak();
        t_glitch();
        check(r7_viol == 0, "R7 pull changed with SCL high", r7_viol, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule